// File: doc/BRIEF.md
# Serial Host Guest Interface

This block is the guest side of a three-wire synchronous serial link to a host microcontroller. The host owns the serial clock and an active-low frame line. The data line is shared and open-drain. The guest never drives it high. It only pulls it low through `host_sdata_pull` and otherwise lets a pull-up hold it high. All three host lines pass through synchronisers into a faster system clock. Every action of the block is taken in the system cycle that follows a detected rising edge of the serial clock.

Each rising serial edge inside a frame closes one slot. A frame opens with a command byte. For the addressed guest this is followed by an acknowledge slot, an 8- or 16-bit register address, an optional burst length and then data bytes. Data bytes flow either from host to guest, with each one written through a simple register port, or from guest to host, with each one read through the same port and shifted out MSB first. Two special command forms exist. The first resets the addressed device. The second carries a 3-bit short command that sets or clears a held soft-reset level or fires one of four control pulses. A frame addressed to every guest is received but never answered.

Top module: `hg_serial_guest`

## Requirements
- R1: After reset the data line is released (`host_sdata_pull`=0), `reg_wr`, `reg_rd`, `dev_reset` and all short-command outputs are 0, and `soft_reset_hold` is 0.
- R2: A frame starts at the first serial rising edge that sees `host_frame_n` low. Command bit 7 is sampled on the next rising edge. Any rising edge that sees `host_frame_n` high ends the frame: the line is released and the next low rising edge starts a fresh frame, even if the previous frame stopped mid-byte.
- R3: The command byte carries, from MSB to LSB: read (1 = guest to host), burst, reset, address-extend, and a 4-bit device field. If the device field is neither `DEV_ID` nor 4'hF, the rest of the frame causes no line drive and no register access.
- R4: For a command equal to `DEV_ID`, the guest pulls the line low for exactly one slot: the slot after the command byte, after each address byte, after the length byte, and after each write byte it accepts.
- R5: A write is performed as a single-cycle `reg_wr` pulse with `reg_addr` and `reg_wdata`. Bytes arrive MSB first. With burst=0 and address-extend=0, the byte after the command is the 8-bit register address.
- R6: With address-extend=1, the address is 16 bits, sent low byte first and then high byte.
- R7: With burst=0, exactly one data byte is written. With burst=1, the byte after the address is a count N, and N bytes are written to consecutive incrementing addresses. Bytes beyond the allowed count are neither written nor acknowledged.
- R8: A read issues `reg_rd` with `reg_addr`. `reg_rdata` must be valid in that same cycle. The byte is sent MSB first: in each of 8 slots the line is pulled low exactly when the data bit is 0. One released slot follows, and then the next byte of a burst begins. After the count is used up, the line stays released.
- R9: With device field 4'hF, the guest never pulls the line. Writes are still performed, and reads are not performed at all.
- R10: With burst=0 and reset=1, `dev_reset` pulses for one cycle and the rest of the frame is ignored.
- R11: With burst=1 and reset=1, the low 3 bits of the next byte are a short command. 000 sets `soft_reset_hold`, 111 clears it, 001 pulses `power_on`, 110 pulses `power_off`, 100 pulses `antishock_enter` and 011 pulses `antishock_exit`. Codes 010 and 101 do nothing.
- R12: `host_sdata_pull` changes only in the system cycle after a synchronised serial rising edge. It stays constant for the rest of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Serial clock from the host |
| host_frame_n | input | 1 | Active-low frame line from the host |
| host_sdata_in | input | 1 | Level seen on the shared data line |
| host_sdata_pull | output | 1 | 1 pulls the shared data line low |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 16 | Register address for the strobe |
| reg_wdata | output | 8 | Write data for `reg_wr` |
| reg_rdata | input | 8 | Read data, valid while `reg_rd` is high |
| dev_reset | output | 1 | One-cycle device reset pulse |
| soft_reset_hold | output | 1 | Held soft-reset level |
| power_on | output | 1 | One-cycle power-on pulse |
| power_off | output | 1 | One-cycle power-off pulse |
| antishock_enter | output | 1 | One-cycle pulse to enter anti-shock mode |
| antishock_exit | output | 1 | One-cycle pulse to leave anti-shock mode |

## Verification
The frames exercise each header shape: 8-bit address, 16-bit address and burst with a length byte. Each shape is run in the write direction and in the read direction, so that acknowledge placement and byte ordering are told apart. Trailing bytes past the allowed count separate a correct counter from one that runs on. A foreign device field, the all-guests field with the host driving its own leading low bit, and the reset-only and short-command forms each isolate one branch of command decoding. A frame cut off mid-byte shows that the end of frame fully reinitialises the slot counting.

// File: rtl/hg_serial_pkg.sv
package hg_serial_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = BYTE_W + 1;
  localparam logic [3:0] BCAST_ID = 4'hF;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_ADLO, PH_ADHI, PH_LEN, PH_SHORT,
    PH_WDATA, PH_ACK, PH_RDATA, PH_GAP, PH_SKIP
  } phase_t;

  typedef struct packed {
    logic       rd;
    logic       burst;
    logic       rst;
    logic       ext;
    logic [3:0] dev;
  } cmd_t;

  function automatic cmd_t cmd_split(input logic [BYTE_W-1:0] b);
    return cmd_t'(b);
  endfunction

  function automatic logic cmd_is_short(input cmd_t c);
    return c.burst & c.rst;
  endfunction

  function automatic logic cmd_is_reset(input cmd_t c);
    return ~c.burst & c.rst;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/hg_line_sync.sv
module hg_line_sync #(
  parameter int               WIDTH  = 3,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] INIT   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/hg_short_decode.sv
module hg_short_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic [2:0] code,
  output logic       soft_hold,
  output logic       pwr_on,
  output logic       pwr_off,
  output logic       as_enter,
  output logic       as_exit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_hold <= 1'b0;
      pwr_on    <= 1'b0;
      pwr_off   <= 1'b0;
      as_enter  <= 1'b0;
      as_exit   <= 1'b0;
    end else begin
      pwr_on   <= 1'b0;
      pwr_off  <= 1'b0;
      as_enter <= 1'b0;
      as_exit  <= 1'b0;
      if (stb) begin
        case (code)
          3'b000:  soft_hold <= 1'b1;
          3'b111:  soft_hold <= 1'b0;
          3'b001:  pwr_on    <= 1'b1;
          3'b110:  pwr_off   <= 1'b1;
          3'b100:  as_enter  <= 1'b1;
          3'b011:  as_exit   <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hg_serial_engine.sv
module hg_serial_engine import hg_serial_pkg::*; #(
  parameter logic [3:0] DEV_ID = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_frame_n,
  input  logic              s_dat,
  output logic              pull,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              dev_reset,
  output logic              short_stb,
  output logic [2:0]        short_code,
  output logic              ev_rise,
  output logic              frame_bcast
);
  logic              clk_prev;
  phase_t            ph, ph_n, after, after_n;
  logic [BYTE_W-1:0] sh, sh_n, tx;
  logic [2:0]        cnt, cnt_n;
  logic              c_rd, c_rd_n, c_burst, c_burst_n, c_ext, c_ext_n;
  logic [3:0]        c_dev, c_dev_n;
  logic [ADDR_W-1:0] addr, addr_n, op_addr_n;
  logic [CNT_W-1:0]  remain, remain_n;
  logic              tx_ok, tx_ok_n, pull_n;
  logic              wr_n, rd_n, drst_n, sstb_n, tx_shift;
  logic [BYTE_W-1:0] wdata_n;
  logic [2:0]        scode_n;
  logic              hdr_end;
  logic [ADDR_W-1:0] hdr_addr;
  logic [CNT_W-1:0]  hdr_cnt;

  assign ev_rise     = s_clk & ~clk_prev;
  assign frame_bcast = (ph != PH_IDLE) && (ph != PH_CMD) && (c_dev == BCAST_ID);

  wire [BYTE_W-1:0] byte_in   = {sh[BYTE_W-2:0], s_dat};
  wire              byte_done = (cnt == 3'd7);
  wire cmd_t        c_in      = cmd_split(byte_in);
  wire              uni       = (c_dev == DEV_ID);
  wire              bc        = (c_dev == BCAST_ID);

  always_comb begin
    ph_n = ph;  after_n = after;  sh_n = sh;  cnt_n = cnt;
    c_rd_n = c_rd;  c_burst_n = c_burst;  c_ext_n = c_ext;  c_dev_n = c_dev;
    addr_n = addr;  remain_n = remain;  tx_ok_n = tx_ok;  pull_n = pull;
    wr_n = 1'b0;  rd_n = 1'b0;  drst_n = 1'b0;  sstb_n = 1'b0;  tx_shift = 1'b0;
    op_addr_n = reg_addr;  wdata_n = reg_wdata;  scode_n = short_code;
    hdr_end = 1'b0;  hdr_addr = addr;  hdr_cnt = remain;
    if (ev_rise) begin
      if (s_frame_n) begin
        ph_n   = PH_IDLE;
        pull_n = 1'b0;
      end else begin
        case (ph)
          PH_IDLE: begin
            ph_n = PH_CMD;  cnt_n = 3'd0;  pull_n = 1'b0;
          end
          PH_CMD, PH_ADLO, PH_ADHI, PH_LEN, PH_SHORT, PH_WDATA: begin
            sh_n  = byte_in;
            cnt_n = cnt + 3'd1;
            if (byte_done) begin
              ph_n    = PH_ACK;
              pull_n  = uni;
              after_n = PH_SKIP;
              case (ph)
                PH_CMD: begin
                  c_rd_n = c_in.rd;  c_burst_n = c_in.burst;
                  c_ext_n = c_in.ext;  c_dev_n = c_in.dev;
                  pull_n = (c_in.dev == DEV_ID);
                  if (c_in.dev != DEV_ID && c_in.dev != BCAST_ID) begin
                    ph_n = PH_SKIP;
                  end else if (cmd_is_reset(c_in)) begin
                    drst_n = 1'b1;
                  end else if (cmd_is_short(c_in)) begin
                    after_n = PH_SHORT;
                  end else begin
                    after_n = PH_ADLO;
                  end
                end
                PH_ADLO: begin
                  addr_n = {{(ADDR_W-BYTE_W){1'b0}}, byte_in};
                  if (c_ext)        after_n = PH_ADHI;
                  else if (c_burst) after_n = PH_LEN;
                  else begin
                    hdr_end = 1'b1;  hdr_addr = addr_n;  hdr_cnt = CNT_W'(1);
                  end
                end
                PH_ADHI: begin
                  addr_n = {byte_in, addr[BYTE_W-1:0]};
                  if (c_burst) after_n = PH_LEN;
                  else begin
                    hdr_end = 1'b1;  hdr_addr = addr_n;  hdr_cnt = CNT_W'(1);
                  end
                end
                PH_LEN: begin
                  hdr_end = 1'b1;  hdr_addr = addr;  hdr_cnt = {1'b0, byte_in};
                end
                PH_SHORT: begin
                  sstb_n = 1'b1;  scode_n = byte_in[2:0];
                end
                default: begin
                  after_n = PH_WDATA;
                  if (remain != '0) begin
                    wr_n = 1'b1;  op_addr_n = addr;  wdata_n = byte_in;
                    addr_n = addr_next(addr);  remain_n = remain - CNT_W'(1);
                  end else begin
                    pull_n = 1'b0;
                  end
                end
              endcase
            end
          end
          PH_ACK: begin
            ph_n   = after;
            cnt_n  = 3'd0;
            pull_n = (after == PH_RDATA) ? ~tx[BYTE_W-1] : 1'b0;
          end
          PH_RDATA: begin
            cnt_n    = cnt + 3'd1;
            tx_shift = 1'b1;
            if (byte_done) begin
              ph_n    = PH_GAP;
              pull_n  = 1'b0;
              tx_ok_n = (remain != '0);
              if (remain != '0) begin
                rd_n = 1'b1;  op_addr_n = addr;
                addr_n = addr_next(addr);  remain_n = remain - CNT_W'(1);
              end
            end else begin
              pull_n = ~tx[BYTE_W-2];
            end
          end
          PH_GAP: begin
            cnt_n = 3'd0;
            if (tx_ok) begin
              ph_n = PH_RDATA;  pull_n = ~tx[BYTE_W-1];
            end else begin
              ph_n = PH_SKIP;   pull_n = 1'b0;
            end
          end
          default: pull_n = 1'b0;
        endcase
      end
    end
    if (hdr_end) begin
      remain_n = hdr_cnt;
      addr_n   = hdr_addr;
      if (!c_rd) begin
        after_n = PH_WDATA;
      end else if (bc || hdr_cnt == '0) begin
        after_n = PH_SKIP;
      end else begin
        after_n   = PH_RDATA;
        rd_n      = 1'b1;
        op_addr_n = hdr_addr;
        addr_n    = addr_next(hdr_addr);
        remain_n  = hdr_cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b1;  ph <= PH_IDLE;  after <= PH_SKIP;
      sh <= '0;  cnt <= '0;  tx <= '0;  tx_ok <= 1'b0;
      c_rd <= 1'b0;  c_burst <= 1'b0;  c_ext <= 1'b0;  c_dev <= '0;
      addr <= '0;  remain <= '0;  pull <= 1'b0;
      reg_wr <= 1'b0;  reg_rd <= 1'b0;  reg_addr <= '0;  reg_wdata <= '0;
      dev_reset <= 1'b0;  short_stb <= 1'b0;  short_code <= '0;
    end else begin
      clk_prev <= s_clk;  ph <= ph_n;  after <= after_n;
      sh <= sh_n;  cnt <= cnt_n;  tx_ok <= tx_ok_n;
      c_rd <= c_rd_n;  c_burst <= c_burst_n;  c_ext <= c_ext_n;  c_dev <= c_dev_n;
      addr <= addr_n;  remain <= remain_n;  pull <= pull_n;
      reg_wr <= wr_n;  reg_rd <= rd_n;  reg_addr <= op_addr_n;  reg_wdata <= wdata_n;
      dev_reset <= drst_n;  short_stb <= sstb_n;  short_code <= scode_n;
      if (reg_rd)        tx <= reg_rdata;
      else if (tx_shift) tx <= {tx[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/hg_serial_guest.sv
module hg_serial_guest import hg_serial_pkg::*; #(
  parameter logic [3:0] DEV_ID      = 4'h3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sclk,
  input  logic              host_frame_n,
  input  logic              host_sdata_in,
  output logic              host_sdata_pull,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              dev_reset,
  output logic              soft_reset_hold,
  output logic              power_on,
  output logic              power_off,
  output logic              antishock_enter,
  output logic              antishock_exit
);
  logic       s_sclk, s_frame_n, s_dat;
  logic       short_stb, ev_rise, frame_bcast;
  logic [2:0] short_code;

  hg_line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({host_sclk, host_frame_n, host_sdata_in}),
    .dout ({s_sclk, s_frame_n, s_dat})
  );

  hg_serial_engine #(.DEV_ID(DEV_ID)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_clk      (s_sclk),
    .s_frame_n  (s_frame_n),
    .s_dat      (s_dat),
    .pull       (host_sdata_pull),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .dev_reset  (dev_reset),
    .short_stb  (short_stb),
    .short_code (short_code),
    .ev_rise    (ev_rise),
    .frame_bcast(frame_bcast)
  );

  hg_short_decode u_short (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (short_stb),
    .code     (short_code),
    .soft_hold(soft_reset_hold),
    .pwr_on   (power_on),
    .pwr_off  (power_off),
    .as_enter (antishock_enter),
    .as_exit  (antishock_exit)
  );
endmodule

// File: rtl/hg_serial_guest_chk.sv
module hg_serial_guest_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_rise,
  input logic s_frame_n,
  input logic frame_bcast,
  input logic pull,
  input logic reg_wr,
  input logic reg_rd,
  input logic dev_reset,
  input logic power_on,
  input logic power_off,
  input logic antishock_enter,
  input logic antishock_exit
);
  p_release_on_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && s_frame_n) |=> !pull);

  p_drive_after_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rise |=> $stable(pull));

  p_bcast_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bcast |-> !pull);

  p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_reset_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> !dev_reset);

  p_short_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({power_on, power_off, antishock_enter, antishock_exit}));
endmodule

bind hg_serial_guest hg_serial_guest_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_rise        (ev_rise),
  .s_frame_n      (s_frame_n),
  .frame_bcast    (frame_bcast),
  .pull           (host_sdata_pull),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .dev_reset      (dev_reset),
  .power_on       (power_on),
  .power_off      (power_off),
  .antishock_enter(antishock_enter),
  .antishock_exit (antishock_exit)
);

// File: tb/hg_serial_guest_bench.sv
module hg_serial_guest_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_clk = 1'b0;
  logic        host_frame_n = 1'b1;
  logic        host_drv = 1'b1;
  logic        pull;
  logic        reg_wr, reg_rd, dev_reset, soft_hold;
  logic        p_on, p_off, a_in, a_out;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  wire         line = host_drv & ~pull;

  int n_cmp = 0, n_bad = 0;
  int c_drst = 0, c_on = 0, c_off = 0, c_in = 0, c_out = 0;
  logic exp_hold = 1'b0;
  bit done = 1'b0;
  logic [23:0] exp_wr[$];
  logic [15:0] exp_rd[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    return (a[7:0] + 8'h11) ^ {a[11:8], a[15:12]};
  endfunction
  assign reg_rdata = model_rd(reg_addr);

  hg_serial_guest u_hg_serial_guest (
    .clk(clk), .rst_n(rst_n), .host_sclk(host_clk), .host_frame_n(host_frame_n),
    .host_sdata_in(line), .host_sdata_pull(pull), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_reset(dev_reset), .soft_reset_hold(soft_hold), .power_on(p_on),
    .power_off(p_off), .antishock_enter(a_in), .antishock_exit(a_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      if (exp_wr.size() == 0) check({8'h0, reg_addr, reg_wdata}, 32'hFFFFFFFF, "R5 unexpected write");
      else check({8'h0, reg_addr, reg_wdata}, {8'h0, exp_wr.pop_front()}, "R5 write addr/data");
    end
    if (reg_rd) begin
      if (exp_rd.size() == 0) check({16'h0, reg_addr}, 32'hFFFFFFFF, "R8 unexpected read");
      else check({16'h0, reg_addr}, {16'h0, exp_rd.pop_front()}, "R8 read addr");
    end
    if (dev_reset) c_drst++;
    if (p_on) c_on++;
    if (p_off) c_off++;
    if (a_in) c_in++;
    if (a_out) c_out++;
  end

  // one slot: host drives hb in the low phase, then the clock rises
  task automatic slot(input logic hb, input logic exp_after, input string req);
    @(negedge clk);
    host_clk = 1'b0;
    host_drv = hb;
    repeat (8) @(negedge clk);
    check({31'h0, pull}, {31'h0, exp_hold}, "R12 drive stable in slot");
    host_clk = 1'b1;
    repeat (6) @(negedge clk);
    check({31'h0, pull}, {31'h0, exp_after}, req);
    exp_hold = exp_after;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_frame();
    @(negedge clk);
    host_frame_n = 1'b0;
    slot(1'b1, 1'b0, "R2 start");
  endtask

  task automatic end_frame();
    @(negedge clk);
    host_frame_n = 1'b1;
    slot(1'b1, 1'b0, "R2 end releases");
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input logic after,
                           input logic hb_ack, input string req);
    for (int i = 7; i >= 0; i--) slot(b[i], (i == 0) ? ack : 1'b0, req);
    slot(hb_ack, after, req);
  endtask

  task automatic recv_byte(input logic [7:0] b, input logic after, input string req);
    for (int i = 6; i >= 0; i--) slot(1'b1, ~b[i], req);
    slot(1'b1, 1'b0, req);
    slot(1'b1, after, req);
  endtask

  task automatic queues_empty(input string req);
    check(exp_wr.size(), 0, req);
    check(exp_rd.size(), 0, req);
  endtask

  task automatic short_cmd(input logic [2:0] code);
    start_frame();
    send_byte(8'h63, 1'b1, 1'b0, 1'b1, "R11 short cmd ack");
    send_byte({5'b0, code}, 1'b1, 1'b0, 1'b1, "R11 code ack");
    end_frame();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({31'h0, pull}, 0, "R1 line released");
    check({30'h0, reg_wr, reg_rd}, 0, "R1 strobes low");
    check({27'h0, soft_hold, p_on, p_off, a_in, a_out}, 0, "R1 short outputs");
    check({31'h0, dev_reset}, 0, "R1 dev_reset");

    // R2: frame aborted mid command, then a full write works
    start_frame();
    for (int i = 0; i < 4; i++) slot(1'b0, 1'b0, "R2 partial");
    end_frame();
    // R5: single write, 8-bit address; extra byte refused (R7)
    exp_wr.push_back({16'h0021, 8'h9C});
    start_frame();
    send_byte(8'h03, 1'b1, 1'b0, 1'b1, "R4 cmd ack");
    send_byte(8'h21, 1'b1, 1'b0, 1'b1, "R4 addr ack");
    send_byte(8'h9C, 1'b1, 1'b0, 1'b1, "R5 data ack");
    send_byte(8'h11, 1'b0, 1'b0, 1'b1, "R7 no ack past limit");
    end_frame();
    queues_empty("R5 single write done");

    // R6: 16-bit address, low byte first
    exp_wr.push_back({16'h1234, 8'h5A});
    start_frame();
    send_byte(8'h13, 1'b1, 1'b0, 1'b1, "R6 cmd ack");
    send_byte(8'h34, 1'b1, 1'b0, 1'b1, "R6 addr lo ack");
    send_byte(8'h12, 1'b1, 1'b0, 1'b1, "R6 addr hi ack");
    send_byte(8'h5A, 1'b1, 1'b0, 1'b1, "R6 data ack");
    end_frame();
    queues_empty("R6 write at 16-bit address");

    // R7: burst write of 2, third byte refused
    exp_wr.push_back({16'h0040, 8'hAA});
    exp_wr.push_back({16'h0041, 8'h55});
    start_frame();
    send_byte(8'h43, 1'b1, 1'b0, 1'b1, "R7 cmd ack");
    send_byte(8'h40, 1'b1, 1'b0, 1'b1, "R7 addr ack");
    send_byte(8'h02, 1'b1, 1'b0, 1'b1, "R7 len ack");
    send_byte(8'hAA, 1'b1, 1'b0, 1'b1, "R7 data0 ack");
    send_byte(8'h55, 1'b1, 1'b0, 1'b1, "R7 data1 ack");
    send_byte(8'h77, 1'b0, 1'b0, 1'b1, "R7 data2 refused");
    end_frame();
    queues_empty("R7 burst write");

    // R8: single read, 8-bit address
    exp_rd.push_back(16'h0010);
    start_frame();
    send_byte(8'h83, 1'b1, 1'b0, 1'b1, "R8 cmd ack");
    send_byte(8'h10, 1'b1, ~model_rd(16'h0010)[7], 1'b1, "R8 addr ack");
    recv_byte(model_rd(16'h0010), 1'b0, "R8 read data");
    slot(1'b1, 1'b0, "R8 released after count");
    end_frame();
    queues_empty("R8 single read");

    // R8: burst read of 2 at a 16-bit address
    exp_rd.push_back(16'h0102);
    exp_rd.push_back(16'h0103);
    start_frame();
    send_byte(8'hD3, 1'b1, 1'b0, 1'b1, "R8 burst cmd ack");
    send_byte(8'h02, 1'b1, 1'b0, 1'b1, "R8 addr lo ack");
    send_byte(8'h01, 1'b1, 1'b0, 1'b1, "R8 addr hi ack");
    send_byte(8'h02, 1'b1, ~model_rd(16'h0102)[7], 1'b1, "R8 len ack");
    recv_byte(model_rd(16'h0102), ~model_rd(16'h0103)[7], "R8 burst byte0");
    recv_byte(model_rd(16'h0103), 1'b0, "R8 burst byte1");
    slot(1'b1, 1'b0, "R8 released after burst");
    end_frame();
    queues_empty("R8 burst read");

    // R3: foreign device, no activity
    start_frame();
    send_byte(8'h05, 1'b0, 1'b0, 1'b1, "R3 no ack foreign");
    send_byte(8'h21, 1'b0, 1'b0, 1'b1, "R3 silent");
    send_byte(8'h44, 1'b0, 1'b0, 1'b1, "R3 silent");
    end_frame();
    queues_empty("R3 no register access");

    // R9: broadcast write performed silently, broadcast read not performed
    exp_wr.push_back({16'h0077, 8'h3C});
    start_frame();
    send_byte(8'h0F, 1'b0, 1'b0, 1'b0, "R9 bcast cmd silent");
    send_byte(8'h77, 1'b0, 1'b0, 1'b0, "R9 bcast addr silent");
    send_byte(8'h3C, 1'b0, 1'b0, 1'b0, "R9 bcast data silent");
    end_frame();
    start_frame();
    send_byte(8'h8F, 1'b0, 1'b0, 1'b0, "R9 bcast read cmd silent");
    send_byte(8'h11, 1'b0, 1'b0, 1'b0, "R9 bcast read addr silent");
    for (int i = 0; i < 9; i++) slot(1'b1, 1'b0, "R9 bcast no read data");
    end_frame();
    queues_empty("R9 bcast write only");

    // R10: reset-only form
    start_frame();
    send_byte(8'h23, 1'b1, 1'b0, 1'b1, "R10 cmd ack");
    send_byte(8'h99, 1'b0, 1'b0, 1'b1, "R10 trailing byte ignored");
    end_frame();
    check(c_drst, 1, "R10 dev_reset pulse count");
    queues_empty("R10 no register access");

    // R11: short commands
    short_cmd(3'b000);
    check({31'h0, soft_hold}, 1, "R11 soft reset set");
    short_cmd(3'b010);
    check({31'h0, soft_hold}, 1, "R11 reserved code keeps hold");
    short_cmd(3'b111);
    check({31'h0, soft_hold}, 0, "R11 soft reset released");
    short_cmd(3'b001);
    short_cmd(3'b110);
    short_cmd(3'b100);
    short_cmd(3'b011);
    short_cmd(3'b101);
    check(c_on, 1, "R11 power on count");
    check(c_off, 1, "R11 power off count");
    check(c_in, 1, "R11 anti-shock enter count");
    check(c_out, 1, "R11 anti-shock exit count");
    check(c_drst, 1, "R10 no extra device reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule